// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sequences the control strobes of a multiplexed address/data local bus in a single-master system. A requester presents a cycle kind: memory read, memory write, I/O read, I/O write or interrupt acknowledge. Once the sequencer accepts it, the block walks through the bus states T1, T2, T3, any number of TW wait states, and T4. While it does so it drives the address-latch pulse, the active-low write strobe, the active-low interrupt-acknowledge strobe and the memory/IO status line.

The current bus state is exported on `phase` so that the address/data multiplexer and the read path can follow the cycle. When an external arbiter grants the bus to another master (`hold_ack` high), the block accepts no new cycle. It also releases the status and write lines: it drops `ctl_oe` and drives a logic one on both lines, so the pad sees a weak high.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle. After that edge `phase` is 0, `ale` is 0, `wr_n` and `inta_n` are 1, `m_io` is 1 and `ctl_oe` is 1.
- R2: `ale` is high only while `clk` is low during T1, and it is low during the high half of T1 and in every other state. It is never released (it has no output enable).
- R3: `phase` encodes the states as idle=0, T1=1, T2=2, T3=3, TW=4 and T4=5. An accepted cycle runs T1, T2, T3, then T4 when `ready` is high at the end of T3, one state per clock.
- R4: `wr_n` is low exactly during T2, T3 and TW of a cycle of kind 1 (memory write) or kind 3 (I/O write). It is high in all other states and for all other kinds.
- R5: `inta_n` is low exactly during T2, T3 and TW of a cycle of kind 4 (interrupt acknowledge), and high otherwise.
- R6: `m_io` is 1 for kinds 0 and 1 (memory) and 0 for kinds 2, 3 and 4. It takes the new cycle's value in the clock in which that cycle is accepted, which is idle or the preceding T4. It holds that value unchanged up to and including the cycle's own T4.
- R7: A TW state follows T3 or TW for each rising edge at which `ready` is low in that state.
- R8: A request is accepted only in idle or T4. The clock after an acceptance is T1, so a request waiting in T4 starts the next cycle with no idle state between. With no acceptance, T4 is followed by idle. A request raised in T1, T2, T3 or TW waits until T4.
- R9: While `hold_ack` is high, no request is accepted, `ctl_oe` is 0, and `m_io` and `wr_n` read 1.
- R10: `req_accept` is high, combinationally, in the clock in which the request is taken. The requester drops or changes its request after that clock.
- R11: Kind codes 5 to 7 are never accepted, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A bus cycle is requested |
| req_kind | input | 3 | Cycle kind: 0 mem read, 1 mem write, 2 I/O read, 3 I/O write, 4 int ack |
| ready | input | 1 | Low extends the cycle with wait states |
| hold_ack | input | 1 | Bus granted to another master |
| req_accept | output | 1 | Request taken in this clock |
| phase | output | 3 | Current bus state code |
| ale | output | 1 | Address latch pulse, low half of T1 |
| wr_n | output | 1 | Active-low write strobe |
| inta_n | output | 1 | Active-low interrupt-acknowledge strobe |
| m_io | output | 1 | 1 for memory, 0 for I/O |
| ctl_oe | output | 1 | Output enable for `m_io` and `wr_n` |

## Verification
`req_accept` and the new `m_io` value follow a request within the same clock, because both are combinational. `phase`, `wr_n` and `inta_n` change one rising edge after the state that causes them, and `ale` follows the falling edge inside T1. The bench drives every input at a falling edge. It samples one nanosecond later, so each check sees a settled low half-cycle. To see the inactive half of T1 it adds one more sample, one nanosecond after the rising edge. Wait-state counts are set by changing `ready` at the falling edge before the rising edge that samples it, so the expected TW count is known exactly.

// File: rtl/mbus_cycle_pkg.sv
// Shared definitions for the bus cycle sequencer: state codes, cycle
// kinds and small decode helpers. Assumes a 3-bit kind field.
package mbus_cycle_pkg;

    localparam int KIND_W  = 3;
    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_t;

    localparam logic [KIND_W-1:0] K_MEM_RD = 3'd0;
    localparam logic [KIND_W-1:0] K_MEM_WR = 3'd1;
    localparam logic [KIND_W-1:0] K_IO_RD  = 3'd2;
    localparam logic [KIND_W-1:0] K_IO_WR  = 3'd3;
    localparam logic [KIND_W-1:0] K_ACK    = 3'd4;

    function automatic logic kind_ok(input logic [KIND_W-1:0] k);
        return k <= K_ACK;
    endfunction

    function automatic logic kind_mem(input logic [KIND_W-1:0] k);
        return (k == K_MEM_RD) || (k == K_MEM_WR);
    endfunction

    function automatic logic kind_wr(input logic [KIND_W-1:0] k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic kind_ack(input logic [KIND_W-1:0] k);
        return k == K_ACK;
    endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
// Bus state register. Steps idle -> T1 -> T2 -> T3 -> (TW)* -> T4 and
// leaves T4 either to T1 (new cycle taken) or to idle.
// Assumes start_cyc is only raised in idle or T4.
module mbus_phase_fsm
    import mbus_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_cyc,
    input  logic       ready,
    output bus_phase_t phase
);

    bus_phase_t phase_nx;

    // Next-state selection.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:      phase_nx = start_cyc ? PH_T1 : PH_IDLE;
            PH_T1:        phase_nx = PH_T2;
            PH_T2:        phase_nx = PH_T3;
            PH_T3, PH_TW: phase_nx = ready ? PH_T4 : PH_TW;
            PH_T4:        phase_nx = start_cyc ? PH_T1 : PH_IDLE;
            default:      phase_nx = PH_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

endmodule

// File: rtl/mbus_kind_reg.sv
// Holds the kind of the cycle in progress, captured when it is taken.
// Resets to memory read so the status line idles high.
module mbus_kind_reg
    import mbus_cycle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [KIND_W-1:0] kind_in,
    output logic [KIND_W-1:0] kind_q
);

    // Capture the kind on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    kind_q <= K_MEM_RD;
        else if (load) kind_q <= kind_in;
    end

endmodule

// File: rtl/mbus_strobe_gen.sv
// Decodes state, cycle kind and clock phase into the bus strobes.
// Assumes hold is only granted while the sequencer is idle; the released
// lines are still forced high as a safeguard.
module mbus_strobe_gen
    import mbus_cycle_pkg::*;
(
    input  logic              clk,
    input  bus_phase_t        phase,
    input  logic [KIND_W-1:0] cur_kind,
    input  logic              take,
    input  logic [KIND_W-1:0] new_kind,
    input  logic              hold,
    output logic              ale,
    output logic              wr_n,
    output logic              inta_n,
    output logic              m_io,
    output logic              ctl_oe
);

    logic strobe_win;

    // Data strobes are open during T2, T3 and wait states.
    always_comb strobe_win = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);

    // Address pulse in the low half of T1 only.
    always_comb ale = (phase == PH_T1) && !clk;

    // Write and acknowledge strobes, active low.
    always_comb begin
        wr_n   = hold ? 1'b1 : !(strobe_win && kind_wr(cur_kind));
        inta_n = !(strobe_win && kind_ack(cur_kind));
    end

    // Status line switches to the new cycle as soon as it is taken.
    always_comb begin
        if (hold)      m_io = 1'b1;
        else if (take) m_io = kind_mem(new_kind);
        else           m_io = kind_mem(cur_kind);
    end

    // Release of status and write lines during hold.
    always_comb ctl_oe = !hold;

endmodule

// File: rtl/mbus_cycle_seq.sv
// Top of the multiplexed bus cycle sequencer. Takes requests in idle or
// T4, runs the state walk and drives the control strobes.
// Assumes the requester keeps req_kind stable until req_accept is seen.
module mbus_cycle_seq
    import mbus_cycle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              ready,
    input  logic              hold_ack,
    output logic              req_accept,
    output logic [PHASE_W-1:0] phase,
    output logic              ale,
    output logic              wr_n,
    output logic              inta_n,
    output logic              m_io,
    output logic              ctl_oe
);

    bus_phase_t        cur_phase;
    logic [KIND_W-1:0] cur_kind;
    logic              slot_open;

    // A new cycle may start only from idle or T4.
    always_comb slot_open = (cur_phase == PH_IDLE) || (cur_phase == PH_T4);

    // Acceptance condition.
    always_comb req_accept = req_valid && !hold_ack && kind_ok(req_kind) && slot_open;

    // Export the state code.
    always_comb phase = cur_phase;

    mbus_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cyc (req_accept),
        .ready     (ready),
        .phase     (cur_phase)
    );

    mbus_kind_reg u_kind (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (req_accept),
        .kind_in (req_kind),
        .kind_q  (cur_kind)
    );

    mbus_strobe_gen u_strb (
        .clk      (clk),
        .phase    (cur_phase),
        .cur_kind (cur_kind),
        .take     (req_accept),
        .new_kind (req_kind),
        .hold     (hold_ack),
        .ale      (ale),
        .wr_n     (wr_n),
        .inta_n   (inta_n),
        .m_io     (m_io),
        .ctl_oe   (ctl_oe)
    );

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
// Property checker for the bus cycle sequencer, bound to the top.
module mbus_cycle_seq_chk
    import mbus_cycle_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               hold_ack,
    input logic               req_accept,
    input logic [PHASE_W-1:0] phase,
    input logic               wr_n,
    input logic               inta_n,
    input logic               m_io,
    input logic               ctl_oe
);

    AST_ACCEPT_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> phase == PH_T1); // R8

    AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> phase == PH_TW); // R7

    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (phase == PH_T2 || phase == PH_T3 || phase == PH_TW)); // R4

    AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> (phase == PH_T2 || phase == PH_T3 || phase == PH_TW)); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !inta_n)); // R4

    AST_MIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 || phase == PH_T3 || phase == PH_TW) |-> $stable(m_io)); // R6

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ctl_oe && m_io && wr_n && !req_accept)); // R9

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .hold_ack   (hold_ack),
    .req_accept (req_accept),
    .phase      (phase),
    .wr_n       (wr_n),
    .inta_n     (inta_n),
    .m_io       (m_io),
    .ctl_oe     (ctl_oe)
);

// File: tb/mbus_cycle_seq_test.sv
`timescale 1ns/1ps
module mbus_cycle_seq_test;

    logic       clk = 1'b0;
    logic       rst_n, req_valid, ready, hold_ack;
    logic [2:0] req_kind;
    logic       req_accept, ale, wr_n, inta_n, m_io, ctl_oe;
    logic [2:0] phase;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mbus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .ready(ready), .hold_ack(hold_ack), .req_accept(req_accept),
        .phase(phase), .ale(ale), .wr_n(wr_n), .inta_n(inta_n),
        .m_io(m_io), .ctl_oe(ctl_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int is_mem(input int k); return (k == 0 || k == 1); endfunction
    function automatic int is_wr(input int k);  return (k == 1 || k == 3); endfunction

    // Reset values.
    task automatic t_reset();
        rst_n = 0; req_valid = 0; req_kind = 0; ready = 1; hold_ack = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 phase", phase, 0);
        chk("R1 ale", ale, 0);
        chk("R1 wr_n", wr_n, 1);
        chk("R1 inta_n", inta_n, 1);
        chk("R1 m_io", m_io, 1);
        chk("R1 ctl_oe", ctl_oe, 1);
        rst_n = 1;
        @(negedge clk);
    endtask

    // One cycle from idle with a given number of wait states.
    task automatic t_cycle(input int kind, input int waits);
        int mio = is_mem(kind);
        int wn  = is_wr(kind) ? 0 : 1;
        int an  = (kind == 4) ? 0 : 1;
        @(negedge clk);
        req_valid = 1; req_kind = 3'(kind);
        #1;
        chk("R10 accept in idle", req_accept, 1);
        chk("R6 m_io at accept", m_io, mio);
        @(posedge clk); #1;
        chk("R3 phase T1", phase, 1);
        chk("R2 ale low in high half of T1", ale, 0);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R2 ale high in low half of T1", ale, 1);
        chk("R4 wr_n idle in T1", wr_n, 1);
        @(negedge clk);
        ready = (waits == 0);
        #1;
        chk("R3 phase T2", phase, 2);
        chk("R2 ale low in T2", ale, 0);
        chk("R4 wr_n in T2", wr_n, wn);
        chk("R5 inta_n in T2", inta_n, an);
        @(negedge clk); #1;
        chk("R3 phase T3", phase, 3);
        chk("R4 wr_n in T3", wr_n, wn);
        chk("R5 inta_n in T3", inta_n, an);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            ready = (i == waits - 1);
            #1;
            chk("R7 phase TW", phase, 4);
            chk("R4 wr_n in TW", wr_n, wn);
            chk("R5 inta_n in TW", inta_n, an);
            chk("R6 m_io held in TW", m_io, mio);
        end
        @(negedge clk); #1;
        chk("R3 phase T4", phase, 5);
        chk("R4 wr_n in T4", wr_n, 1);
        chk("R5 inta_n in T4", inta_n, 1);
        chk("R6 m_io held in T4", m_io, mio);
        @(negedge clk);
        ready = 1;
        #1;
        chk("R8 idle after T4", phase, 0);
        chk("R2 ale low in idle", ale, 0);
    endtask

    // Request raised mid-cycle waits for T4, then runs back to back.
    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1; req_kind = 3'd1;
        #1;
        chk("R10 first accept", req_accept, 1);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R3 phase T1 first", phase, 1);
        @(negedge clk);
        req_valid = 1; req_kind = 3'd2;
        #1;
        chk("R8 no accept in T2", req_accept, 0);
        chk("R6 m_io not switched in T2", m_io, 1);
        chk("R4 wr_n still write in T2", wr_n, 0);
        @(negedge clk); #1;
        chk("R8 no accept in T3", req_accept, 0);
        @(negedge clk); #1;
        chk("R3 phase T4 first", phase, 5);
        chk("R8 accept in T4", req_accept, 1);
        chk("R6 m_io switches in T4", m_io, 0);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R8 T4 goes straight to T1", phase, 1);
        chk("R6 m_io io in T1", m_io, 0);
        @(negedge clk); #1;
        chk("R4 wr_n high for io read", wr_n, 1);
        repeat (2) @(negedge clk);
        #1;
        chk("R3 phase T4 second", phase, 5);
        @(negedge clk); #1;
        chk("R8 idle after second", phase, 0);
    endtask

    // Hold acknowledge blocks requests and releases the lines.
    task automatic t_hold();
        @(negedge clk);
        hold_ack = 1; req_valid = 1; req_kind = 3'd3;
        #1;
        chk("R9 ctl_oe in hold", ctl_oe, 0);
        chk("R9 m_io in hold", m_io, 1);
        chk("R9 wr_n in hold", wr_n, 1);
        chk("R9 no accept in hold", req_accept, 0);
        @(negedge clk); #1;
        chk("R9 stays idle in hold", phase, 0);
        hold_ack = 0;
        #1;
        chk("R9 accept after hold", req_accept, 1);
        chk("R6 io status after hold", m_io, 0);
        @(negedge clk);
        req_valid = 0;
        repeat (4) @(negedge clk);
        #1;
        chk("R8 idle after post-hold cycle", phase, 0);
    endtask

    // Undefined kinds are refused.
    task automatic t_bad_kind();
        for (int k = 5; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1; req_kind = 3'(k);
            #1;
            chk("R11 no accept for bad kind", req_accept, 0);
            @(negedge clk); #1;
            chk("R11 stays idle for bad kind", phase, 0);
        end
        req_valid = 0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_cycle(0, 0);
        t_cycle(1, 0);
        t_cycle(2, 2);
        t_cycle(3, 1);
        t_cycle(4, 3);
        t_back_to_back();
        t_hold();
        t_bad_kind();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule